// File: doc/BRIEF.md
# Multi-Space Carrier Bus Slave Decoder

This block is the slave end of a 16-bit mezzanine carrier bus. The master raises one of four space selects: memory, interrupt, identification or I/O. It holds an 18-bit word address, a direction, two byte-lane enables and write data stable until the slave acknowledges. The block decides which space the cycle belongs to and classifies it as a low-byte, high-byte or whole-word transfer. It then waits a number of clocks that depends on the space and the direction, and raises acknowledge for a single clock.

Identification reads return a small fixed table that ends in a computed check word. I/O cycles reach a 16-bit control register and a read-only status word. Interrupt reads return a fixed vector. Memory cycles are forwarded to a downstream controller port, and the data from that port is returned on reads. The memory wait count follows a static strap that tells the block whether the bus runs at the slow or the fast clock rate.

Top module: `mspace_bus_slave`

## Requirements
- R1: When several selects are high at once, the cycle goes to the first space in the order memory, interrupt, identification, I/O.
- R2: Interrupt and I/O reads take 1 wait state and their writes take 0. Identification reads take 1. A cycle with W wait states raises acknowledge in the clock that follows the (W+1)-th rising edge counted from the first edge that samples the select.
- R3: Memory reads and writes take 3 wait states when `cfg_fast` is 0 and 8 wait states when `cfg_fast` is 1.
- R4: Acknowledge is high for exactly one clock per cycle. It stays low while the select remains high after that clock, and a new cycle starts only once all selects have been seen low.
- R5: Read data is valid in the acknowledge clock and reads as zero in every other clock.
- R6: Identification words 0 to 3 read 0x5A17, 0x0C40, 0x0003 and their XOR, 0x5654. Word addresses 4 and above read zero.
- R7: A write to identification space is acknowledged with 0 wait states. It changes neither the control register nor the table.
- R8: The control register is zero after reset. I/O word 0 reads and writes it, and I/O word 1 returns `io_status`. Other I/O words read zero, and writes to them have no effect.
- R9: `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8. A write updates only the enabled lanes. A read returns zero on lanes that are not enabled.
- R10: During the wait states of a memory cycle, `mem_req` is high and `mem_addr`, `mem_wr`, `mem_be` and `mem_wdata` carry the cycle's values. `mem_req` is low in the acknowledge clock. A memory read returns `mem_rdata`.
- R11: Interrupt-space reads return 0x00B4. Interrupt-space writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fast | input | 1 | Static strap: 1 selects the fast-clock memory wait count |
| sel_mem | input | 1 | Memory space select |
| sel_int | input | 1 | Interrupt space select |
| sel_id | input | 1 | Identification space select |
| sel_io | input | 1 | I/O space select |
| bus_rd | input | 1 | 1 for read, 0 for write |
| bus_addr | input | 18 | Word address |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-clock acknowledge |
| io_status | input | 16 | Status word returned at I/O word 1 |
| ctrl_q | output | 16 | Control register contents |
| mem_req | output | 1 | Downstream memory request |
| mem_wr | output | 1 | Downstream write flag |
| mem_addr | output | 18 | Downstream word address |
| mem_be | output | 2 | Downstream byte-lane enables |
| mem_wdata | output | 16 | Downstream write data |
| mem_rdata | input | 16 | Downstream read data |

## Verification
Every space is tried in both directions, and the measured wait count is compared with the space and direction table. That separates a wrong count from a wrong space route. Memory cycles are run under both strap settings, so a memory path that ignores the strap is caught.

Combined selects expose a wrong priority, because each combination used returns a different word from the space that should win. Low-only, high-only, empty and full lane enables on control-register writes and reads separate correct lane steering from a swapped or ignored enable. A write to the identification space is followed by reads of the control register and the table, which confirms the write had no effect.

// File: rtl/mspace_pkg.sv
// Shared types and helpers for the multi-space carrier bus slave.
// Assumes every consumer imports the package rather than redefining the encodings.
package mspace_pkg;

    // Space a bus cycle is routed to.
    typedef enum logic [2:0] {
        SP_NONE = 3'd0,
        SP_MEM  = 3'd1,
        SP_INT  = 3'd2,
        SP_ID   = 3'd3,
        SP_IO   = 3'd4
    } space_e;

    // Cycle sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Larger of two counts, used to size the wait counter.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mspace_decode.sv
// Space and wait-count decoder.
// Turns the four select strobes into one space, with fixed priority, and looks up
// the wait-state count for that space and direction. Purely combinational.
// Assumes the caller sizes WAIT_W to hold the largest count.
module mspace_decode
    import mspace_pkg::*;
#(
    parameter int unsigned WAIT_W     = 4,
    parameter int unsigned W_INT_RD   = 1,
    parameter int unsigned W_INT_WR   = 0,
    parameter int unsigned W_ID_RD    = 1,
    parameter int unsigned W_IO_RD    = 1,
    parameter int unsigned W_IO_WR    = 0,
    parameter int unsigned W_MEM_SLOW = 3,
    parameter int unsigned W_MEM_FAST = 8
) (
    input  logic              sel_mem,
    input  logic              sel_int,
    input  logic              sel_id,
    input  logic              sel_io,
    input  logic              rd_in,
    input  logic              cfg_fast,
    output space_e            space_o,
    output logic [WAIT_W-1:0] waits_o,
    output logic              any_sel_o
);

    // Fixed-priority choice of the space: memory first, I/O last.
    always_comb begin
        if (sel_mem)      space_o = SP_MEM;
        else if (sel_int) space_o = SP_INT;
        else if (sel_id)  space_o = SP_ID;
        else if (sel_io)  space_o = SP_IO;
        else              space_o = SP_NONE;
    end

    assign any_sel_o = sel_mem | sel_int | sel_id | sel_io;

    // Wait-state lookup by space, direction and clock strap.
    always_comb begin
        unique case (space_o)
            SP_MEM:  waits_o = cfg_fast ? WAIT_W'(W_MEM_FAST) : WAIT_W'(W_MEM_SLOW);
            SP_INT:  waits_o = rd_in ? WAIT_W'(W_INT_RD) : WAIT_W'(W_INT_WR);
            SP_ID:   waits_o = rd_in ? WAIT_W'(W_ID_RD) : '0;
            SP_IO:   waits_o = rd_in ? WAIT_W'(W_IO_RD) : WAIT_W'(W_IO_WR);
            default: waits_o = '0;
        endcase
    end

endmodule

// File: rtl/mspace_seq.sv
// Cycle sequencer.
// Captures a new cycle when a select appears while idle and counts down its wait
// states. It raises acknowledge for one clock, then waits for every select to drop.
// It also presents the fields of the cycle in progress: the live bus while idle,
// the captured copy afterwards.
// Assumes the master holds every bus field stable until acknowledge.
module mspace_seq
    import mspace_pkg::*;
#(
    parameter int unsigned AW     = 18,
    parameter int unsigned DW     = 16,
    parameter int unsigned BW     = DW / 8,
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_sel,
    input  space_e            space_in,
    input  logic [WAIT_W-1:0] waits_in,
    input  logic              rd_in,
    input  logic [AW-1:0]     addr_in,
    input  logic [BW-1:0]     be_in,
    input  logic [DW-1:0]     wdata_in,
    output logic              fire_o,
    output logic              ack_o,
    output logic              busy_o,
    output space_e            cur_space,
    output logic              cur_rd,
    output logic [AW-1:0]     cur_addr,
    output logic [BW-1:0]     cur_be,
    output logic [DW-1:0]     cur_wdata
);

    seq_state_e        st;
    logic [WAIT_W-1:0] cnt;
    space_e            cap_space;
    logic              cap_rd;
    logic [AW-1:0]     cap_addr;
    logic [BW-1:0]     cap_be;
    logic [DW-1:0]     cap_wdata;

    // Strobe for the clock in which the cycle completes and acknowledge is set.
    assign fire_o = ((st == ST_IDLE) && any_sel && (waits_in == '0)) ||
                    ((st == ST_WAIT) && (cnt == WAIT_W'(1)));

    assign busy_o = (st == ST_WAIT);

    // Fields of the current cycle: the live bus while idle, the captured copy after.
    always_comb begin
        if (st == ST_IDLE) begin
            cur_space = space_in;
            cur_rd    = rd_in;
            cur_addr  = addr_in;
            cur_be    = be_in;
            cur_wdata = wdata_in;
        end else begin
            cur_space = cap_space;
            cur_rd    = cap_rd;
            cur_addr  = cap_addr;
            cur_be    = cap_be;
            cur_wdata = cap_wdata;
        end
    end

    // State, wait counter, acknowledge and cycle capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            ack_o     <= 1'b0;
            cap_space <= SP_NONE;
            cap_rd    <= 1'b0;
            cap_addr  <= '0;
            cap_be    <= '0;
            cap_wdata <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    ack_o <= 1'b0;
                    if (any_sel) begin
                        cap_space <= space_in;
                        cap_rd    <= rd_in;
                        cap_addr  <= addr_in;
                        cap_be    <= be_in;
                        cap_wdata <= wdata_in;
                        if (waits_in == '0) begin
                            ack_o <= 1'b1;
                            st    <= ST_DONE;
                        end else begin
                            cnt <= waits_in;
                            st  <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    cnt <= cnt - WAIT_W'(1);
                    if (cnt == WAIT_W'(1)) begin
                        ack_o <= 1'b1;
                        st    <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    ack_o <= 1'b0;
                    if (!any_sel) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R4
    AST_WAIT_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (cnt != '0)); // R3
    AST_NO_REACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && any_sel) |=> !ack_o); // R4

endmodule

// File: rtl/mspace_regs.sv
// Read-data and register file.
// Holds the control register, builds the identification table, and chooses read data
// for the space of the current cycle. It masks unused byte lanes and registers the
// result so that it appears together with acknowledge.
// Assumes fire marks the single clock in which a cycle completes.
module mspace_regs
    import mspace_pkg::*;
#(
    parameter int unsigned AW         = 18,
    parameter int unsigned DW         = 16,
    parameter int unsigned BW         = DW / 8,
    parameter logic [DW-1:0] ID_VENDOR  = 16'h5A17,
    parameter logic [DW-1:0] ID_MODEL   = 16'h0C40,
    parameter logic [DW-1:0] ID_REV     = 16'h0003,
    parameter logic [DW-1:0] INT_VECTOR = 16'h00B4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  space_e        space,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] be,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] io_status,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] ctrl_o
);

    localparam int unsigned LANE_W = DW / BW;
    localparam logic [DW-1:0] ID_CHECK = ID_VENDOR ^ ID_MODEL ^ ID_REV;

    logic [DW-1:0] raw_rd;
    logic [DW-1:0] masked_rd;
    logic          ctrl_we;

    // Identification table lookup; words past the table read zero.
    function automatic logic [DW-1:0] id_word(input logic [AW-1:0] a);
        if (a == AW'(0))      return ID_VENDOR;
        else if (a == AW'(1)) return ID_MODEL;
        else if (a == AW'(2)) return ID_REV;
        else if (a == AW'(3)) return ID_CHECK;
        else                  return '0;
    endfunction

    // Raw read source by space and word address.
    always_comb begin
        unique case (space)
            SP_MEM:  raw_rd = mem_rdata;
            SP_INT:  raw_rd = INT_VECTOR;
            SP_ID:   raw_rd = id_word(addr);
            SP_IO: begin
                if (addr == AW'(0))      raw_rd = ctrl_o;
                else if (addr == AW'(1)) raw_rd = io_status;
                else                     raw_rd = '0;
            end
            default: raw_rd = '0;
        endcase
    end

    assign ctrl_we = fire && !rd && (space == SP_IO) && (addr == AW'(0));

    // One lane per byte enable: read masking and control-register storage.
    for (genvar l = 0; l < BW; l++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        assign masked_rd[l*LANE_W +: LANE_W] = be[l] ? raw_rd[l*LANE_W +: LANE_W] : '0;
        assign ctrl_o[l*LANE_W +: LANE_W]    = lane_q;

        // Control-register byte update on an enabled I/O word-0 write.
        always_ff @(posedge clk) begin
            if (!rst_n)                lane_q <= '0;
            else if (ctrl_we && be[l]) lane_q <= wdata[l*LANE_W +: LANE_W];
        end
    end

    // Read data register: loaded with the acknowledge, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_o <= '0;
        else if (fire && rd) rdata_o <= masked_rd;
        else                 rdata_o <= '0;
    end

    AST_ID_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rd && space == SP_ID) |=> $stable(ctrl_o)); // R7
    AST_CTRL_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_o == '0)); // R8
    AST_CTRL_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(ctrl_o)); // R8

endmodule

// File: rtl/mspace_bus_slave.sv
// Top level of the multi-space carrier bus slave.
// Joins the decoder, the cycle sequencer and the register/read-data unit, and drives
// the downstream memory controller port from the cycle in progress.
// Assumes one master that keeps its selects and fields stable until acknowledge.
module mspace_bus_slave
    import mspace_pkg::*;
#(
    parameter int unsigned AW         = 18,
    parameter int unsigned DW         = 16,
    parameter int unsigned BW         = DW / 8,
    parameter int unsigned W_INT_RD   = 1,
    parameter int unsigned W_INT_WR   = 0,
    parameter int unsigned W_ID_RD    = 1,
    parameter int unsigned W_IO_RD    = 1,
    parameter int unsigned W_IO_WR    = 0,
    parameter int unsigned W_MEM_SLOW = 3,
    parameter int unsigned W_MEM_FAST = 8,
    parameter logic [DW-1:0] ID_VENDOR  = 16'h5A17,
    parameter logic [DW-1:0] ID_MODEL   = 16'h0C40,
    parameter logic [DW-1:0] ID_REV     = 16'h0003,
    parameter logic [DW-1:0] INT_VECTOR = 16'h00B4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fast,
    input  logic          sel_mem,
    input  logic          sel_int,
    input  logic          sel_id,
    input  logic          sel_io,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_be,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ack,
    input  logic [DW-1:0] io_status,
    output logic [DW-1:0] ctrl_q,
    output logic          mem_req,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [BW-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int unsigned MAX_W  = max_u(max_u(max_u(W_MEM_FAST, W_MEM_SLOW),
                                                 max_u(W_INT_RD, W_INT_WR)),
                                           max_u(max_u(W_IO_RD, W_IO_WR), W_ID_RD));
    localparam int unsigned WAIT_W = $clog2(MAX_W + 1);

    space_e            dec_space;
    logic [WAIT_W-1:0] dec_waits;
    logic              any_sel;
    logic              fire;
    logic              busy;
    space_e            cur_space;
    logic              cur_rd;
    logic [AW-1:0]     cur_addr;
    logic [BW-1:0]     cur_be;
    logic [DW-1:0]     cur_wdata;

    mspace_decode #(
        .WAIT_W(WAIT_W), .W_INT_RD(W_INT_RD), .W_INT_WR(W_INT_WR), .W_ID_RD(W_ID_RD),
        .W_IO_RD(W_IO_RD), .W_IO_WR(W_IO_WR), .W_MEM_SLOW(W_MEM_SLOW), .W_MEM_FAST(W_MEM_FAST)
    ) u_decode (
        .sel_mem(sel_mem), .sel_int(sel_int), .sel_id(sel_id), .sel_io(sel_io),
        .rd_in(bus_rd), .cfg_fast(cfg_fast),
        .space_o(dec_space), .waits_o(dec_waits), .any_sel_o(any_sel)
    );

    mspace_seq #(.AW(AW), .DW(DW), .BW(BW), .WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .any_sel(any_sel),
        .space_in(dec_space), .waits_in(dec_waits), .rd_in(bus_rd),
        .addr_in(bus_addr), .be_in(bus_be), .wdata_in(bus_wdata),
        .fire_o(fire), .ack_o(bus_ack), .busy_o(busy),
        .cur_space(cur_space), .cur_rd(cur_rd), .cur_addr(cur_addr),
        .cur_be(cur_be), .cur_wdata(cur_wdata)
    );

    mspace_regs #(
        .AW(AW), .DW(DW), .BW(BW), .ID_VENDOR(ID_VENDOR), .ID_MODEL(ID_MODEL),
        .ID_REV(ID_REV), .INT_VECTOR(INT_VECTOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .fire(fire), .space(cur_space), .rd(cur_rd),
        .addr(cur_addr), .be(cur_be), .wdata(cur_wdata),
        .mem_rdata(mem_rdata), .io_status(io_status),
        .rdata_o(bus_rdata), .ctrl_o(ctrl_q)
    );

    // Downstream memory port follows the captured cycle while it waits.
    assign mem_req   = busy && (cur_space == SP_MEM);
    assign mem_wr    = !cur_rd;
    assign mem_addr  = cur_addr;
    assign mem_be    = cur_be;
    assign mem_wdata = cur_wdata;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0)); // R5
    AST_MEM_REQ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> sel_mem); // R1
    AST_MEM_REQ_ENDS_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> bus_ack); // R10

endmodule

// File: tb/test_mspace_bus_slave.sv
// Directed bench for the multi-space carrier bus slave: a bus master model and a
// small downstream memory model, with one task per scenario.
module test_mspace_bus_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fast = 1'b0;
    logic        sel_mem = 1'b0, sel_int = 1'b0, sel_id = 1'b0, sel_io = 1'b0;
    logic        bus_rd = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic [15:0] io_status = 16'h9C21;
    logic [15:0] ctrl_q;
    logic        mem_req, mem_wr;
    logic [17:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    logic [15:0] mem_model [16];
    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mspace_bus_slave i_mspace_bus_slave (
        .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast),
        .sel_mem(sel_mem), .sel_int(sel_int), .sel_id(sel_id), .sel_io(sel_io),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .io_status(io_status), .ctrl_q(ctrl_q),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Downstream memory model: combinational read, lane-wise write while requested.
    assign mem_rdata = mem_model[mem_addr[3:0]];
    always @(posedge clk) begin
        if (mem_req && mem_wr) begin
            if (mem_be[0]) mem_model[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem_model[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; sel is {mem,int,id,io}. Returns the data and the waits measured.
    task automatic bus_cycle(input logic [3:0] sel, input logic rd, input logic [17:0] addr,
                             input logic [1:0] be, input logic [15:0] wd,
                             output logic [15:0] rdat, output int waits);
        int req_bad;
        req_bad = 0;
        waits = 0;
        @(negedge clk);
        {sel_mem, sel_int, sel_id, sel_io} = sel;
        bus_rd = rd; bus_addr = addr; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        while (!bus_ack && waits < 40) begin
            if (sel[3] && !(mem_req && mem_addr == addr && mem_wr == !rd &&
                            mem_be == be && (rd || mem_wdata == wd))) req_bad++;
            if (!sel[3] && mem_req) req_bad++;
            waits++;
            @(negedge clk);
        end
        rdat = bus_rdata;
        if (mem_req) req_bad++;
        chk("R10 memory port during cycle", req_bad, 0);
        @(negedge clk);
        chk("R4 ack low while select held", {31'd0, bus_ack}, 0);
        chk("R5 rdata zero after ack", {16'd0, bus_rdata}, 0);
        {sel_mem, sel_int, sel_id, sel_io} = 4'b0000;
    endtask

    task automatic t_reset;
        chk("R8 control reset", {16'd0, ctrl_q}, 0);
        chk("R4 ack after reset", {31'd0, bus_ack}, 0);
        chk("R5 rdata after reset", {16'd0, bus_rdata}, 0);
        chk("R10 mem_req after reset", {31'd0, mem_req}, 0);
    endtask

    task automatic t_id_reads;
        logic [15:0] d; int w;
        logic [15:0] exp_tab [5];
        exp_tab = '{16'h5A17, 16'h0C40, 16'h0003, 16'h5654, 16'h0000};
        for (int i = 0; i < 5; i++) begin
            bus_cycle(4'b0010, 1'b1, 18'(i), 2'b11, 16'h0, d, w);
            chk("R6 id word", {16'd0, d}, {16'd0, exp_tab[i]});
            chk("R2 id read waits", w, 1);
        end
    endtask

    task automatic t_io_ctrl;
        logic [15:0] d; int w;
        bus_cycle(4'b0001, 1'b0, 18'd0, 2'b11, 16'hC3A5, d, w);
        chk("R2 io write waits", w, 0);
        chk("R8 control after write", {16'd0, ctrl_q}, 32'hC3A5);
        bus_cycle(4'b0001, 1'b1, 18'd0, 2'b11, 16'h0, d, w);
        chk("R2 io read waits", w, 1);
        chk("R8 control readback", {16'd0, d}, 32'hC3A5);
        bus_cycle(4'b0001, 1'b1, 18'd1, 2'b11, 16'h0, d, w);
        chk("R8 status word", {16'd0, d}, 32'h9C21);
        bus_cycle(4'b0001, 1'b1, 18'd2, 2'b11, 16'h0, d, w);
        chk("R8 unused io word", {16'd0, d}, 0);
        bus_cycle(4'b0001, 1'b0, 18'd1, 2'b11, 16'hFFFF, d, w);
        chk("R8 status write ignored", {16'd0, ctrl_q}, 32'hC3A5);
    endtask

    task automatic t_byte_lanes;
        logic [15:0] d; int w;
        bus_cycle(4'b0001, 1'b0, 18'd0, 2'b01, 16'h7E7E, d, w);
        chk("R9 low lane write", {16'd0, ctrl_q}, 32'hC37E);
        bus_cycle(4'b0001, 1'b0, 18'd0, 2'b10, 16'h1100, d, w);
        chk("R9 high lane write", {16'd0, ctrl_q}, 32'h117E);
        bus_cycle(4'b0001, 1'b0, 18'd0, 2'b00, 16'hFFFF, d, w);
        chk("R9 no lane write", {16'd0, ctrl_q}, 32'h117E);
        bus_cycle(4'b0001, 1'b1, 18'd0, 2'b01, 16'h0, d, w);
        chk("R9 low lane read", {16'd0, d}, 32'h007E);
        bus_cycle(4'b0001, 1'b1, 18'd0, 2'b10, 16'h0, d, w);
        chk("R9 high lane read", {16'd0, d}, 32'h1100);
    endtask

    task automatic t_id_write;
        logic [15:0] d; int w;
        bus_cycle(4'b0010, 1'b0, 18'd0, 2'b11, 16'hFFFF, d, w);
        chk("R7 id write waits", w, 0);
        chk("R7 control untouched", {16'd0, ctrl_q}, 32'h117E);
        bus_cycle(4'b0010, 1'b1, 18'd0, 2'b11, 16'h0, d, w);
        chk("R7 id table untouched", {16'd0, d}, 32'h5A17);
    endtask

    task automatic t_int_space;
        logic [15:0] d; int w;
        bus_cycle(4'b0100, 1'b1, 18'd9, 2'b11, 16'h0, d, w);
        chk("R11 int vector", {16'd0, d}, 32'h00B4);
        chk("R2 int read waits", w, 1);
        bus_cycle(4'b0100, 1'b0, 18'd0, 2'b11, 16'h5555, d, w);
        chk("R2 int write waits", w, 0);
        chk("R11 int write no effect", {16'd0, ctrl_q}, 32'h117E);
        bus_cycle(4'b0100, 1'b1, 18'd0, 2'b11, 16'h0, d, w);
        chk("R11 int vector after write", {16'd0, d}, 32'h00B4);
    endtask

    task automatic t_mem(input logic fast);
        logic [15:0] d; int w; int exp_w;
        exp_w = fast ? 8 : 3;
        cfg_fast = fast;
        bus_cycle(4'b1000, 1'b1, 18'd5, 2'b11, 16'h0, d, w);
        chk("R3 mem read waits", w, exp_w);
        chk("R10 mem read data", {16'd0, d}, 32'hA005);
        bus_cycle(4'b1000, 1'b0, 18'd6, 2'b11, fast ? 16'h1234 : 16'h4321, d, w);
        chk("R3 mem write waits", w, exp_w);
        bus_cycle(4'b1000, 1'b1, 18'd6, 2'b11, 16'h0, d, w);
        chk("R10 mem write readback", {16'd0, d}, fast ? 32'h1234 : 32'h4321);
    endtask

    task automatic t_priority;
        logic [15:0] d; int w;
        cfg_fast = 1'b0;
        bus_cycle(4'b1001, 1'b1, 18'd5, 2'b11, 16'h0, d, w);
        chk("R1 mem over io data", {16'd0, d}, 32'hA005);
        chk("R1 mem over io waits", w, 3);
        bus_cycle(4'b0111, 1'b1, 18'd0, 2'b11, 16'h0, d, w);
        chk("R1 int over id and io", {16'd0, d}, 32'h00B4);
        bus_cycle(4'b0011, 1'b1, 18'd0, 2'b11, 16'h0, d, w);
        chk("R1 id over io", {16'd0, d}, 32'h5A17);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem_model[i] = 16'hA000 + 16'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_reads();
        t_io_ctrl();
        t_byte_lanes();
        t_id_write();
        t_int_space();
        t_mem(1'b0);
        t_mem(1'b1);
        t_priority();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule